// File: doc/BRIEF.md
# Persistent Write Bank-Striding Remapper

Writes that belong to one persistent-memory log tend to hit a single bank, because each log occupies one or a few contiguous address regions. When several logs are written together, that clustering serialises the traffic on one bank while the other banks stay idle. This block sits in the request path of a memory controller and rewrites only the bank field of each request tagged persistent. The new bank is the original bank plus the log number times a fixed stride, plus a fixed offset, taken modulo the bank count. Requests from different logs that target the same local address therefore land in different banks and can be serviced in parallel.

The remap holds no state. The new address depends only on the request itself, so no lookup table is needed. Reads of persistent data go through the same arithmetic, so a read finds the location that the matching write used. Requests not tagged persistent keep their address. The block adds one registered stage with a valid/ready handshake.

Top module: `pmstripe_remap`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0.
- R2: For a request with `in_persist`=1, the output bank field is `(bank + in_log*STRIDE + OFFSET) mod 2**BANK_W`. The bank field is address bits `[BANK_LSB +: BANK_W]`, with defaults BANK_LSB=10, BANK_W=3, STRIDE=1 and OFFSET=3.
- R3: Every address bit outside the bank field is copied unchanged to the output.
- R4: A request with `in_persist`=0 leaves with its address unchanged, whatever its log number.
- R5: A read (`in_write`=0) and a write (`in_write`=1) with the same address, log number and persistent flag leave with the same address.
- R6: `in_data`, `in_write`, `in_persist` and `in_log` appear unchanged on the matching outputs.
- R7: A request accepted on a rising edge (`in_valid` and `in_ready` both high) is presented on the outputs, with `out_valid`=1, after that same edge.
- R8: While `out_valid`=1 and `out_ready`=0, every output holds its value and `in_ready` is 0. A request waiting at the input is accepted on the edge at which the held one drains.
- R9: The bank sum wraps modulo the bank count. With the defaults, bank 7 at log 5 maps to bank 7.
- R10: With the defaults, logs 0 through 7 that use the same address land in eight distinct banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request taken on this edge if valid |
| in_addr | input | 32 | Original request address |
| in_write | input | 1 | 1 = write, 0 = read |
| in_persist | input | 1 | Request targets persistent memory |
| in_log | input | 4 | Log number of the request |
| in_data | input | 32 | Write payload |
| out_valid | output | 1 | Remapped request present |
| out_ready | input | 1 | Downstream takes the request |
| out_addr | output | 32 | Remapped address |
| out_write | output | 1 | Carried access direction |
| out_persist | output | 1 | Carried persistent flag |
| out_log | output | 4 | Carried log number |
| out_data | output | 32 | Carried payload |

## Verification
The hardest case to reach is a full output register while the downstream stalls and a second request waits at the input. The output must hold for several cycles, the input must stay blocked, and the waiting request must be taken on exactly the edge that drains the held one. The stimulus creates this case by dropping `out_ready` before the first request is sent. It then presents the second request, holds the stall for several cycles and releases it. Bank wrap-around is forced by choosing a high bank together with a high log number. The spreading property is checked by sending one address under all eight log numbers.

// File: rtl/pmstripe_pkg.sv
package pmstripe_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LOG_W  = 4;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        acc_e              acc;
        logic              persist;
        logic [LOG_W-1:0]  log_id;
        logic [DATA_W-1:0] data;
    } req_t;

    // Full-width bank displacement for one log; callers keep the low bits.
    function automatic logic [31:0] stripe_delta(logic [LOG_W-1:0] log_id,
                                                 int unsigned stride,
                                                 int unsigned offset);
        return 32'(log_id) * stride + offset;
    endfunction

endpackage

// File: rtl/pmstripe_bank_map.sv
module pmstripe_bank_map
    import pmstripe_pkg::*;
#(
    parameter int BANK_LSB = 10,
    parameter int BANK_W   = 3,
    parameter int STRIDE   = 1,
    parameter int OFFSET   = 3
) (
    input  req_t req_i,
    output req_t req_o
);

    generate
        if (BANK_LSB + BANK_W > ADDR_W) begin : g_bad_field
            $error("bank field lies outside the address");
        end
    endgenerate

    logic [31:0]       delta;
    logic [BANK_W-1:0] bank_new;

    always_comb begin
        delta    = stripe_delta(req_i.log_id, STRIDE, OFFSET);
        bank_new = req_i.addr[BANK_LSB +: BANK_W] + delta[BANK_W-1:0];
        req_o    = req_i;
        if (req_i.persist) begin
            req_o.addr[BANK_LSB +: BANK_W] = bank_new;
        end
    end

endmodule

// File: rtl/pmstripe_slice.sv
module pmstripe_slice
    import pmstripe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  req_t in_req,
    output logic out_valid,
    input  logic out_ready,
    output req_t out_req
);

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
            out_req <= in_req;
        end
    end

    assert_reset_empty_R1: assert property (@(posedge clk) rst |=> !out_valid);

    assert_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_req));

    assert_block_input_R8: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid);

endmodule

// File: rtl/pmstripe_remap.sv
module pmstripe_remap
    import pmstripe_pkg::*;
#(
    parameter int BANK_LSB = 10,
    parameter int BANK_W   = 3,
    parameter int STRIDE   = 1,
    parameter int OFFSET   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  logic              in_persist,
    input  logic [LOG_W-1:0]  in_log,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_write,
    output logic              out_persist,
    output logic [LOG_W-1:0]  out_log,
    output logic [DATA_W-1:0] out_data
);

    localparam logic [ADDR_W-1:0] BANK_MASK = ADDR_W'((2 ** BANK_W) - 1) << BANK_LSB;
    localparam logic [BANK_W-1:0] OFF_MOD   = BANK_W'(OFFSET);

    req_t req_in, req_mapped, req_out;

    always_comb begin
        req_in.addr    = in_addr;
        req_in.acc     = in_write ? ACC_WRITE : ACC_READ;
        req_in.persist = in_persist;
        req_in.log_id  = in_log;
        req_in.data    = in_data;
    end

    pmstripe_bank_map #(
        .BANK_LSB (BANK_LSB),
        .BANK_W   (BANK_W),
        .STRIDE   (STRIDE),
        .OFFSET   (OFFSET)
    ) u_map (
        .req_i (req_in),
        .req_o (req_mapped)
    );

    pmstripe_slice u_slice (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_req    (req_mapped),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_req   (req_out)
    );

    assign out_addr    = req_out.addr;
    assign out_write   = (req_out.acc == ACC_WRITE);
    assign out_persist = req_out.persist;
    assign out_log     = req_out.log_id;
    assign out_data    = req_out.data;

    assert_keep_rowcol_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> (out_addr & ~BANK_MASK) == ($past(in_addr) & ~BANK_MASK));

    assert_plain_pass_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !in_persist |=> out_addr == $past(in_addr));

    assert_log0_offset_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_persist && in_log == '0 |=>
        BANK_W'(out_addr[BANK_LSB +: BANK_W] - $past(in_addr[BANK_LSB +: BANK_W])) == OFF_MOD);

    assert_payload_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_data == $past(in_data) && out_write == $past(in_write)
        && out_persist == $past(in_persist) && out_log == $past(in_log));

endmodule

// File: tb/tb_pmstripe_remap.sv
module tb_pmstripe_remap;

    localparam int CLK_PERIOD = 10;
    localparam int STRIDE_TB  = 1;
    localparam int OFFSET_TB  = 3;
    localparam int NB         = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, in_write, in_persist;
    logic [31:0] in_addr, in_data;
    logic [3:0]  in_log;
    logic        out_valid, out_ready, out_write, out_persist;
    logic [31:0] out_addr, out_data;
    logic [3:0]  out_log;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmstripe_remap dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .in_write(in_write), .in_persist(in_persist), .in_log(in_log), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_write(out_write), .out_persist(out_persist), .out_log(out_log), .out_data(out_data)
    );

    function automatic logic [31:0] model_addr(logic [31:0] a, logic p, logic [3:0] l);
        logic [31:0] r;
        int b;
        r = a;
        if (p) begin
            b = (int'(a[12:10]) + int'(l) * STRIDE_TB + OFFSET_TB) % NB;
            r[12:10] = b[2:0];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic w, input logic p,
                         input logic [3:0] l, input logic [31:0] d);
        in_addr = a; in_write = w; in_persist = p; in_log = l; in_data = d;
        in_valid = 1'b1;
    endtask

    // One request with downstream ready; outputs checked one edge later.
    task automatic xfer(input logic [31:0] a, input logic w, input logic p,
                        input logic [3:0] l, input logic [31:0] d, input string req,
                        output logic [31:0] got);
        @(negedge clk);
        drive(a, w, p, l, d);
        @(negedge clk);
        in_valid = 1'b0;
        got = out_addr;
        check(out_valid == 1'b1, "R7", 64'(out_valid), 64'd1);
        check(out_addr == model_addr(a, p, l), req, 64'(out_addr), 64'(model_addr(a, p, l)));
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        in_addr = '0; in_write = 1'b0; in_persist = 1'b0; in_log = '0; in_data = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
    endtask

    task automatic t_persist_map;
        logic [31:0] g;
        xfer(32'h0000_0000, 1'b1, 1'b1, 4'd0, 32'h11, "R2", g);
        xfer(32'hABCD_0555, 1'b1, 1'b1, 4'd2, 32'h22, "R2", g);
        check((g & ~32'h1C00) == (32'hABCD_0555 & ~32'h1C00), "R3", 64'(g), 64'(32'hABCD_0555));
        xfer(32'hFFFF_E3FF, 1'b1, 1'b1, 4'd1, 32'h33, "R3", g);
    endtask

    task automatic t_wrap;
        logic [31:0] g;
        xfer(32'h0000_1C00, 1'b1, 1'b1, 4'd5, 32'h44, "R9", g);
        check(g[12:10] == 3'd7, "R9", 64'(g[12:10]), 64'd7);
        xfer(32'h0000_1400, 1'b1, 1'b1, 4'd15, 32'h45, "R9", g);
    endtask

    task automatic t_plain;
        logic [31:0] g;
        xfer(32'h1234_5678, 1'b1, 1'b0, 4'd6, 32'h55, "R4", g);
        check(g == 32'h1234_5678, "R4", 64'(g), 64'h1234_5678);
        xfer(32'h0000_1C00, 1'b0, 1'b0, 4'd3, 32'h56, "R4", g);
    endtask

    task automatic t_read_same;
        logic [31:0] gw, gr;
        xfer(32'h0040_0800, 1'b1, 1'b1, 4'd4, 32'h66, "R5", gw);
        xfer(32'h0040_0800, 1'b0, 1'b1, 4'd4, 32'h0, "R5", gr);
        check(gw == gr, "R5", 64'(gr), 64'(gw));
    endtask

    task automatic t_payload;
        @(negedge clk);
        drive(32'h0000_0400, 1'b0, 1'b1, 4'd9, 32'hDEAD_BEEF);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_data == 32'hDEAD_BEEF, "R6", 64'(out_data), 64'hDEAD_BEEF);
        check(out_write == 1'b0, "R6", 64'(out_write), 64'd0);
        check(out_persist == 1'b1, "R6", 64'(out_persist), 64'd1);
        check(out_log == 4'd9, "R6", 64'(out_log), 64'd9);
    endtask

    task automatic t_spread;
        logic [7:0] seen = '0;
        logic [31:0] g;
        for (int l = 0; l < 8; l++) begin
            xfer(32'h0000_0C00, 1'b1, 1'b1, 4'(l), 32'(l), "R10", g);
            seen[g[12:10]] = 1'b1;
        end
        check(seen == 8'hFF, "R10", 64'(seen), 64'hFF);
    endtask

    task automatic t_backpressure;
        @(negedge clk);
        out_ready = 1'b0;
        drive(32'h0000_0000, 1'b1, 1'b1, 4'd1, 32'hA1);
        @(negedge clk);
        check(out_valid == 1'b1, "R7", 64'(out_valid), 64'd1);
        drive(32'h0000_0400, 1'b1, 1'b1, 4'd2, 32'hB2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R8", 64'(in_ready), 64'd0);
            check(out_valid && out_data == 32'hA1 && out_addr == 32'h0000_1000, "R8",
                  64'(out_data), 64'hA1);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_data == 32'hB2, "R8", 64'(out_data), 64'hB2);
        check(out_addr == model_addr(32'h0000_0400, 1'b1, 4'd2), "R2", 64'(out_addr),
              64'(model_addr(32'h0000_0400, 1'b1, 4'd2)));
        @(negedge clk);
        check(out_valid == 1'b0, "R7", 64'(out_valid), 64'd0);
    endtask

    initial begin
        t_reset();
        t_persist_map();
        t_wrap();
        t_plain();
        t_read_same();
        t_payload();
        t_spread();
        t_backpressure();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule